// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a 16-bit signal processor. It holds two 16-bit operand registers (X and Y), a 32-bit product register (P), a 32-bit accumulator (A) and a 16-bit status word. The zero and negative flags live inside the status word. Each clock, a command selected by a 3-bit opcode may be applied.

The multiply is fractional: the signed product of X and Y is doubled and kept to 32 bits. The multiply-accumulate command first re-forms P from the X and Y already held. It adds that new P to A and loads fresh X and Y from the operand inputs, all in one clock. A clear-and-load command zeroes A, clears the top four status bits and loads X and Y. Three modifiers act on A: shift left by one, negate, and absolute value. All arithmetic wraps modulo 2^32.

Commands travel on a valid/ready pair. Every command finishes in one clock, so `cmd_ready` is always high and there is never back-pressure. A command is taken on every rising edge at which `cmd_valid` is high. The status word can also be written whole through a plain write-enable port.

Top module: `fmac_core`

## Requirements
- R1: While reset is held (synchronous, active low), X, Y, P, A and the status word all read 0.
- R2: On a multiply-accumulate (opcode 1), P becomes the signed product of the X and Y held before the edge, shifted left by one and truncated to 32 bits. For example, X=Y=0x8000 gives P=0x80000000. No other command changes P.
- R3: On a multiply-accumulate, A becomes the old A plus the new P (mod 2^32), and X and Y take `opnd_x` and `opnd_y`, all at the same edge.
- R4: After a multiply-accumulate, shift, negate or absolute-value command, status bit 13 (zero flag) is 1 exactly when the new A is 0, and status bit 15 (negative flag) equals bit 31 of the new A. Other status bits keep their value.
- R5: Clear-and-load (opcode 2) sets A to 0, clears status bits 15..12 (so the zero flag reads 0), loads X and Y, and leaves P alone.
- R6: Shift (opcode 3) sets A to A shifted left by one; bit 31 is lost.
- R7: Negate (opcode 4) sets A to its two's complement (0 stays 0).
- R8: Absolute value (opcode 5) negates A only when bit 31 of A is set; 0x80000000 stays 0x80000000 with the negative flag set.
- R9: Opcodes 0, 6 and 7, or `cmd_valid` low, change none of X, Y, P, A or the status word.
- R10: With `st_we` high, the status word takes `st_wdata` at the edge; if a command is taken in the same cycle, the bits that command updates override the written value.
- R11: `cmd_ready` is high in every cycle out of reset, and each cycle with `cmd_valid` high applies exactly one command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Command accepted (always high) |
| cmd_op | input | 3 | Opcode: 1 MAC, 2 clear-and-load, 3 shift, 4 negate, 5 absolute |
| opnd_x | input | 16 | New X operand for load commands |
| opnd_y | input | 16 | New Y operand for load commands |
| st_we | input | 1 | Status word write enable |
| st_wdata | input | 16 | Status word write value |
| x_q | output | 16 | X operand register |
| y_q | output | 16 | Y operand register |
| p_q | output | 32 | Product register |
| a_q | output | 32 | Accumulator |
| st_q | output | 16 | Status word (bit 15 negative, bit 13 zero) |
| flag_z | output | 1 | Zero flag (status bit 13) |
| flag_n | output | 1 | Negative flag (status bit 15) |

## Verification
Some rules are checked by assertions on every cycle:
- the doubled product is formed from the operands held before the edge;
- the accumulate sum, the shift and the negation are correct;
- absolute value leaves a non-negative A unchanged;
- the flags agree with the new A;
- clear-and-load empties A and the top status bits;
- idle or unused opcodes freeze all state.

Other behaviour only the bench's scenarios can show: the wrap at X=Y=0x8000, absolute value of 0x80000000, a status write colliding with a flag-updating command, and long mixed runs checked against a behavioural model every clock.

// File: rtl/fmac_pkg.sv
package fmac_pkg;
  localparam int unsigned OPW = 3;
  localparam logic [OPW-1:0] OP_NOP   = 3'd0;
  localparam logic [OPW-1:0] OP_MAC   = 3'd1;
  localparam logic [OPW-1:0] OP_CLRLD = 3'd2;
  localparam logic [OPW-1:0] OP_SHL   = 3'd3;
  localparam logic [OPW-1:0] OP_NEG   = 3'd4;
  localparam logic [OPW-1:0] OP_ABS   = 3'd5;
  localparam int unsigned STW   = 16;
  localparam int unsigned ST_N  = 15;
  localparam int unsigned ST_Z  = 13;
  localparam int unsigned TOPW  = 4;
endpackage

// File: rtl/fmac_mul.sv
module fmac_mul #(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = 2 * DW
) (
  input  logic [DW-1:0] mul_a,
  input  logic [DW-1:0] mul_b,
  output logic [AW-1:0] frac_prod
);
  logic signed [AW-1:0] full;
  always_comb begin
    full      = AW'($signed(mul_a)) * AW'($signed(mul_b));
    frac_prod = full << 1;
  end
endmodule

// File: rtl/fmac_alu.sv
module fmac_alu #(
  parameter int unsigned AW = 32
) (
  input  logic                      take,
  input  logic [fmac_pkg::OPW-1:0]  op,
  input  logic [AW-1:0]             acc,
  input  logic [AW-1:0]             prod,
  output logic [AW-1:0]             acc_nxt,
  output logic                      flag_upd,
  output logic                      ld_ops,
  output logic                      ld_prod,
  output logic                      clr_top
);
  import fmac_pkg::*;
  logic [AW-1:0] neg_acc;
  assign neg_acc = AW'(0) - acc;

  always_comb begin
    acc_nxt  = acc;
    flag_upd = 1'b0;
    ld_ops   = 1'b0;
    ld_prod  = 1'b0;
    clr_top  = 1'b0;
    if (take) begin
      unique case (op)
        OP_MAC: begin
          acc_nxt  = acc + prod;
          flag_upd = 1'b1;
          ld_ops   = 1'b1;
          ld_prod  = 1'b1;
        end
        OP_CLRLD: begin
          acc_nxt = '0;
          ld_ops  = 1'b1;
          clr_top = 1'b1;
        end
        OP_SHL: begin
          acc_nxt  = {acc[AW-2:0], 1'b0};
          flag_upd = 1'b1;
        end
        OP_NEG: begin
          acc_nxt  = neg_acc;
          flag_upd = 1'b1;
        end
        OP_ABS: begin
          acc_nxt  = acc[AW-1] ? neg_acc : acc;
          flag_upd = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fmac_status.sv
module fmac_status #(
  parameter int unsigned AW = 32
) (
  input  logic [fmac_pkg::STW-1:0] st_cur,
  input  logic                     wr_en,
  input  logic [fmac_pkg::STW-1:0] wr_val,
  input  logic                     clr_top,
  input  logic                     flag_upd,
  input  logic [AW-1:0]            acc_nxt,
  output logic [fmac_pkg::STW-1:0] st_nxt
);
  import fmac_pkg::*;
  always_comb begin
    st_nxt = wr_en ? wr_val : st_cur;
    if (clr_top) st_nxt[STW-1 -: TOPW] = '0;
    if (flag_upd) begin
      st_nxt[ST_Z] = (acc_nxt == '0);
      st_nxt[ST_N] = acc_nxt[AW-1];
    end
  end
endmodule

// File: rtl/fmac_core.sv
module fmac_core #(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = 2 * DW
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_valid,
  output logic                      cmd_ready,
  input  logic [fmac_pkg::OPW-1:0]  cmd_op,
  input  logic [DW-1:0]             opnd_x,
  input  logic [DW-1:0]             opnd_y,
  input  logic                      st_we,
  input  logic [fmac_pkg::STW-1:0]  st_wdata,
  output logic [DW-1:0]             x_q,
  output logic [DW-1:0]             y_q,
  output logic [AW-1:0]             p_q,
  output logic [AW-1:0]             a_q,
  output logic [fmac_pkg::STW-1:0]  st_q,
  output logic                      flag_z,
  output logic                      flag_n
);
  import fmac_pkg::*;

  logic          take;
  logic [AW-1:0] prod_new;
  logic [AW-1:0] acc_nxt;
  logic          flag_upd, ld_ops, ld_prod, clr_top;
  logic [STW-1:0] st_nxt;

  assign cmd_ready = 1'b1;
  assign take      = cmd_valid & cmd_ready;

  fmac_mul #(.DW(DW)) u_mul (
    .mul_a(x_q), .mul_b(y_q), .frac_prod(prod_new)
  );

  fmac_alu #(.AW(AW)) u_alu (
    .take(take), .op(cmd_op), .acc(a_q), .prod(prod_new),
    .acc_nxt(acc_nxt), .flag_upd(flag_upd), .ld_ops(ld_ops),
    .ld_prod(ld_prod), .clr_top(clr_top)
  );

  fmac_status #(.AW(AW)) u_st (
    .st_cur(st_q), .wr_en(st_we), .wr_val(st_wdata), .clr_top(clr_top),
    .flag_upd(flag_upd), .acc_nxt(acc_nxt), .st_nxt(st_nxt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q  <= '0;
      y_q  <= '0;
      p_q  <= '0;
      a_q  <= '0;
      st_q <= '0;
    end else begin
      if (ld_ops) begin
        x_q <= opnd_x;
        y_q <= opnd_y;
      end
      if (ld_prod) p_q <= prod_new;
      a_q  <= acc_nxt;
      st_q <= st_nxt;
    end
  end

  assign flag_z = st_q[ST_Z];
  assign flag_n = st_q[ST_N];
endmodule

// File: rtl/fmac_core_chk.sv
module fmac_core_chk #(
  parameter int unsigned DW = 16,
  localparam int unsigned AW = 2 * DW
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      cmd_valid,
  input logic                      cmd_ready,
  input logic [fmac_pkg::OPW-1:0]  cmd_op,
  input logic [DW-1:0]             opnd_x,
  input logic [DW-1:0]             opnd_y,
  input logic                      st_we,
  input logic [fmac_pkg::STW-1:0]  st_wdata,
  input logic [DW-1:0]             x_q,
  input logic [DW-1:0]             y_q,
  input logic [AW-1:0]             p_q,
  input logic [AW-1:0]             a_q,
  input logic [fmac_pkg::STW-1:0]  st_q,
  input logic                      flag_z,
  input logic                      flag_n
);
  import fmac_pkg::*;
  logic          go;
  logic          quiet;
  logic          flag_op;
  logic [AW-1:0] ref_prod;

  assign go      = cmd_valid && cmd_ready;
  assign quiet   = !st_we && (!cmd_valid || cmd_op == OP_NOP || cmd_op > OP_ABS);
  assign flag_op = go && (cmd_op == OP_MAC || cmd_op == OP_SHL ||
                          cmd_op == OP_NEG || cmd_op == OP_ABS);
  assign ref_prod = AW'(AW'($signed(x_q)) * AW'($signed(y_q))) << 1;

  AST_MAC_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == OP_MAC |=> p_q == $past(ref_prod)); // R2
  AST_MAC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == OP_MAC |=> a_q == $past(a_q) + p_q); // R3
  AST_MAC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == OP_MAC |=> x_q == $past(opnd_x) && y_q == $past(opnd_y)); // R3
  AST_FLAGS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    flag_op |=> flag_z == (a_q == '0) && flag_n == a_q[AW-1]); // R4
  AST_CLEAR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == OP_CLRLD |=> a_q == '0 && st_q[15:12] == 4'h0 && $stable(p_q)); // R5
  AST_SHIFT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == OP_SHL |=> a_q == {$past(a_q[AW-2:0]), 1'b0}); // R6
  AST_NEGATE: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == OP_NEG |=> a_q + $past(a_q) == '0); // R7
  AST_ABS_POSITIVE: assert property (@(posedge clk) disable iff (!rst_n)
    go && cmd_op == OP_ABS && !a_q[AW-1] |=> $stable(a_q)); // R8
  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> $stable(a_q) && $stable(p_q) && $stable(x_q) && $stable(y_q) && $stable(st_q)); // R9
  AST_STATUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    st_we && !cmd_valid |=> st_q == $past(st_wdata)); // R10
endmodule

bind fmac_core fmac_core_chk #(.DW(DW)) u_chk (.*);

// File: tb/sim_fmac_core.sv
module sim_fmac_core;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [2:0]  cmd_op;
  logic [15:0] opnd_x, opnd_y;
  logic        st_we;
  logic [15:0] st_wdata;
  logic [15:0] x_q, y_q, st_q;
  logic [31:0] p_q, a_q;
  logic        flag_z, flag_n;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [15:0] mx, my, mst;
  logic [31:0] mp, ma;

  always #2 clk = ~clk;

  fmac_core u0 (.*);

  function automatic logic [31:0] frac(input logic [15:0] a, input logic [15:0] b);
    longint pa, pb;
    pa = longint'($signed(a));
    pb = longint'($signed(b));
    return 32'(pa * pb * 2);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%08h expected=%08h", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "x", 32'(x_q), 32'(mx));
    chk(req, "y", 32'(y_q), 32'(my));
    chk(req, "p", p_q, mp);
    chk(req, "a", a_q, ma);
    chk(req, "status", 32'(st_q), 32'(mst));
    chk(req, "flag_z", 32'(flag_z), 32'(mst[13]));
    chk(req, "flag_n", 32'(flag_n), 32'(mst[15]));
    chk("R11", "cmd_ready", 32'(cmd_ready), 32'd1);
  endtask

  // Drive at the falling edge, advance the model, compare at the next falling edge.
  task automatic step(input logic v, input logic [2:0] op, input logic [15:0] x,
                      input logic [15:0] y, input logic we, input logic [15:0] wd,
                      input string req);
    logic [31:0] na;
    logic [15:0] nst;
    logic        fl;
    cmd_valid = v; cmd_op = op; opnd_x = x; opnd_y = y; st_we = we; st_wdata = wd;
    na  = ma;
    nst = we ? wd : mst;
    fl  = 1'b0;
    if (v) begin
      case (op)
        3'd1: begin mp = frac(mx, my); na = ma + mp; mx = x; my = y; fl = 1'b1; end
        3'd2: begin na = 32'd0; nst[15:12] = 4'h0; mx = x; my = y; end
        3'd3: begin na = ma << 1; fl = 1'b1; end
        3'd4: begin na = -ma; fl = 1'b1; end
        3'd5: begin na = ma[31] ? -ma : ma; fl = 1'b1; end
        default: ;
      endcase
    end
    if (fl) begin
      nst[13] = (na == 32'd0);
      nst[15] = na[31];
    end
    ma = na; mst = nst;
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b1; cmd_op = 3'd1; opnd_x = 16'h1234;
    opnd_y = 16'h5678; st_we = 1'b1; st_wdata = 16'hFFFF;
    mx = '0; my = '0; mp = '0; ma = '0; mst = '0;
    repeat (3) @(negedge clk);
    compare("R1");                       // R1 reset values
    rst_n = 1'b1;

    // R3 / R2: load, then accumulate
    step(1, 3'd2, 16'h4000, 16'h4000, 0, 0, "R5");
    step(1, 3'd1, 16'h0003, 16'hFFFE, 0, 0, "R2");   // P = 0.5*0.5 -> 0x20000000
    step(1, 3'd1, 16'h8000, 16'h8000, 0, 0, "R3");   // P = 3*-2*2 = -12
    step(1, 3'd1, 16'h0000, 16'h0000, 0, 0, "R2");   // R2 corner: 0x8000^2 -> 0x80000000
    step(1, 3'd1, 16'h7FFF, 16'h8000, 0, 0, "R4");   // product zero, flags from A
    step(1, 3'd1, 16'h0001, 16'h0001, 0, 0, "R3");
    // R6 shift with overflow out of bit 31
    step(1, 3'd3, 16'hAAAA, 16'h5555, 0, 0, "R6");
    step(1, 3'd3, 0, 0, 0, 0, "R6");
    // R7 negate
    step(1, 3'd4, 0, 0, 0, 0, "R7");
    step(1, 3'd4, 0, 0, 0, 0, "R7");
    // R8 absolute value on negative, positive, and the most negative value
    step(1, 3'd2, 16'hFFFF, 16'h0001, 0, 0, "R5");
    step(1, 3'd1, 0, 0, 0, 0, "R4");                  // A = -2
    step(1, 3'd5, 0, 0, 0, 0, "R8");
    step(1, 3'd5, 0, 0, 0, 0, "R8");
    step(1, 3'd2, 16'h8000, 16'h8000, 0, 0, "R5");
    step(1, 3'd1, 0, 0, 0, 0, "R2");                  // A = 0x80000000
    step(1, 3'd5, 0, 0, 0, 0, "R8");
    // R7 negate of zero keeps the zero flag
    step(1, 3'd2, 0, 0, 0, 0, "R5");
    step(1, 3'd4, 0, 0, 0, 0, "R7");
    // R5 clear-and-load after flags set: zero flag reads 0, low bits kept
    step(1, 3'd0, 0, 0, 1, 16'hF0F3, "R10");
    step(1, 3'd2, 16'h1111, 16'h2222, 0, 0, "R5");
    // R9 ignored opcodes and valid low, operands toggling
    step(1, 3'd6, 16'hDEAD, 16'hBEEF, 0, 0, "R9");
    step(1, 3'd7, 16'hCAFE, 16'hF00D, 0, 0, "R9");
    step(0, 3'd1, 16'h1357, 16'h2468, 0, 0, "R9");
    step(0, 3'd4, 16'h0, 16'h0, 0, 0, "R9");
    // R10 status write colliding with flag and clear commands
    step(1, 3'd1, 16'h0100, 16'h0100, 1, 16'h5A5A, "R10");
    step(1, 3'd2, 16'h0002, 16'h0003, 1, 16'hFFFF, "R10");
    step(0, 3'd0, 0, 0, 1, 16'h0123, "R10");

    // mixed run compared every clock
    for (int i = 0; i < 400; i++) begin
      logic [2:0] rop;
      rop = 3'($urandom_range(0, 7));
      step(($urandom % 4) != 0, rop, 16'($urandom), 16'($urandom),
           ($urandom % 8) == 0, 16'($urandom), "R3");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule